// File: doc/BRIEF.md
# Clock Gating Set/Clear Controller

This block switches a group of system clocks and a group of peripheral clocks on and off under control of a small memory-mapped register interface. Each group has its own pair of write-only command addresses. One address turns clocks on and the other turns them off, and in both cases only the bits written as 1 act. A read-only state address reports which clocks of the group are currently running. Software never needs a read-modify-write cycle. Several clocks can be switched with one write, and the clocks that a write does not name are never disturbed.

Every state bit drives one glitch-free clock gate. Each system clock has its own source clock input. The peripheral clocks are derived from the bus clock. A separate read-only flags address gathers four readiness indications from outside the block and brings them into the bus clock domain: oscillator stable, two PLL locks and master clock ready.

Top module: `ckg_ctrl`

## Requirements
- R1: While rst_ni is low and right after it rises, both state addresses read 0 and every gated clock output stays low.
- R2: A write to address 0x0 turns on each system clock whose bit is 1 in wdata_i[NSYS-1:0] and leaves the other system clocks as they were. The new state is readable at address 0x2 from the cycle after the write.
- R3: A write to address 0x1 turns off each system clock whose bit is 1 in wdata_i[NSYS-1:0] and leaves the other system clocks as they were.
- R4: The peripheral clocks behave the same way, using address 0x4 to turn clocks on, 0x5 to turn them off, and 0x6 to read their state.
- R5: The following have no effect on any state bit: data bits written as 0, data bits at or above the group width, and writes to read-only or unmapped addresses.
- R6: Clearing the unused clocks of both groups, one write per group, leaves every other clock on.
- R7: Address 0x8 reads the flags at bit 0 (oscillator stable), bit 1 (PLL A lock), bit 2 (PLL B lock) and bit 3 (master clock ready). Each flag passes through two flops, so a change at the input appears after the second rising clk_i edge.
- R8: Reads of the command addresses 0x0, 0x1, 0x4, 0x5 and of unmapped addresses return 0. State reads are zero-extended.
- R9: A gated output follows its source clock while its state bit is 1 and stays low while it is 0. The enable is taken on the falling edge of the source, so no high pulse is ever shortened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, also the source of the peripheral clocks |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | AW | Word address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for addr_i |
| sys_src_clk_i | input | NSYS | Source clock of each system clock |
| osc_stable_i | input | 1 | Main oscillator stable flag |
| pll_a_lock_i | input | 1 | PLL A lock flag |
| pll_b_lock_i | input | 1 | PLL B lock flag |
| mck_ready_i | input | 1 | Master clock ready flag |
| sys_clk_o | output | NSYS | Gated system clocks |
| per_clk_o | output | NPER | Gated peripheral clocks |

## Verification
The bench builds the block with NSYS=4 and NPER=6, narrower than the 32-bit data bus. With these widths, data bits above each group width reach the command registers, so the test can confirm that they are dropped, and the zero-extension of state reads becomes visible. The small groups also allow masks that cover all ones, all zeros and mixed patterns. The system sources run at half the bus rate, so both gate flavours are exercised against distinct source clocks.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
  localparam int unsigned AW = 4;
  localparam logic [AW-1:0] A_SYS_ON    = 4'h0;
  localparam logic [AW-1:0] A_SYS_OFF   = 4'h1;
  localparam logic [AW-1:0] A_SYS_STATE = 4'h2;
  localparam logic [AW-1:0] A_PER_ON    = 4'h4;
  localparam logic [AW-1:0] A_PER_OFF   = 4'h5;
  localparam logic [AW-1:0] A_PER_STATE = 4'h6;
  localparam logic [AW-1:0] A_FLAGS     = 4'h8;
  localparam int unsigned NFLAG = 4;
endpackage

// File: rtl/ckg_bank.sv
module ckg_bank #(
  parameter int unsigned W  = 8,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          on_i,
  input  logic          off_i,
  input  logic [DW-1:0] wdata_i,
  output logic [W-1:0]  state_o
);
  logic [W-1:0] mask;
  assign mask = wdata_i[W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_o <= '0;
    else if (on_i)  state_o <= state_o | mask;
    else if (off_i) state_o <= state_o & ~mask;
  end

  AST_ON_SETS_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_i |=> state_o == ($past(state_o) | $past(wdata_i[W-1:0]))); // R2
  AST_OFF_CLEARS_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_i && !on_i) |=> state_o == ($past(state_o) & ~$past(wdata_i[W-1:0]))); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(on_i || off_i) |=> $stable(state_o)); // R5
endmodule

// File: rtl/ckg_gate.sv
module ckg_gate (
  input  logic src_clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic clk_o
);
  logic en_q;
  // enable moves only while the source is low
  always_ff @(negedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;
  end
  assign clk_o = src_clk_i & en_q;
endmodule

// File: rtl/ckg_flag_sync.sv
module ckg_flag_sync #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] flag_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] meta_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      flag_o <= '0;
    end else begin
      meta_q <= flag_i;
      flag_o <= meta_q;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_FLAG_RISE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_o[i]) |-> $past(flag_i[i], 2)); // R7
  end
endmodule

// File: rtl/ckg_ctrl.sv
module ckg_ctrl
  import ckg_pkg::*;
#(
  parameter int unsigned NSYS = 8,
  parameter int unsigned NPER = 16,
  parameter int unsigned DW   = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic            wr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [NSYS-1:0] sys_src_clk_i,
  input  logic            osc_stable_i,
  input  logic            pll_a_lock_i,
  input  logic            pll_b_lock_i,
  input  logic            mck_ready_i,
  output logic [NSYS-1:0] sys_clk_o,
  output logic [NPER-1:0] per_clk_o
);
  logic [NSYS-1:0]  sys_state;
  logic [NPER-1:0]  per_state;
  logic [NFLAG-1:0] flags_raw, flags_q;

  ckg_bank #(.W(NSYS), .DW(DW)) u_sys_bank (
    .clk_i, .rst_ni,
    .on_i   (wr_i && addr_i == A_SYS_ON),
    .off_i  (wr_i && addr_i == A_SYS_OFF),
    .wdata_i,
    .state_o(sys_state)
  );

  ckg_bank #(.W(NPER), .DW(DW)) u_per_bank (
    .clk_i, .rst_ni,
    .on_i   (wr_i && addr_i == A_PER_ON),
    .off_i  (wr_i && addr_i == A_PER_OFF),
    .wdata_i,
    .state_o(per_state)
  );

  assign flags_raw = {mck_ready_i, pll_b_lock_i, pll_a_lock_i, osc_stable_i};

  ckg_flag_sync #(.N(NFLAG)) u_flags (
    .clk_i, .rst_ni,
    .flag_i(flags_raw),
    .flag_o(flags_q)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_SYS_STATE: rdata_o[NSYS-1:0]  = sys_state;
      A_PER_STATE: rdata_o[NPER-1:0]  = per_state;
      A_FLAGS:     rdata_o[NFLAG-1:0] = flags_q;
      default:     rdata_o = '0;
    endcase
  end

  for (genvar i = 0; i < NSYS; i++) begin : g_sys_gate
    ckg_gate u_gate (
      .src_clk_i(sys_src_clk_i[i]), .rst_ni,
      .en_i(sys_state[i]), .clk_o(sys_clk_o[i])
    );
  end

  for (genvar i = 0; i < NPER; i++) begin : g_per_gate
    ckg_gate u_gate (
      .src_clk_i(clk_i), .rst_ni,
      .en_i(per_state[i]), .clk_o(per_clk_o[i])
    );
  end

  AST_RO_WRITE_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i != A_SYS_ON && addr_i != A_SYS_OFF && addr_i != A_PER_ON
     && addr_i != A_PER_OFF) |=> ($stable(sys_state) && $stable(per_state))); // R5
endmodule

// File: tb/ckg_ctrl_tb.sv
module ckg_ctrl_tb_top;
  localparam int NSYS = 4;
  localparam int NPER = 6;
  localparam int DW   = 32;

  logic clk = 0, src_clk = 0, rst_n = 0;
  logic [3:0] addr = '0;
  logic wr = 0;
  logic [DW-1:0] wdata = '0, rdata;
  logic osc = 0, plla = 0, pllb = 0, mckr = 0;
  logic [NSYS-1:0] sys_clk;
  logic [NPER-1:0] per_clk;
  int checks = 0, fails = 0;
  bit done = 0;
  int sys_edges = 0, per_edges = 0;

  always #10 clk = ~clk;
  always #20 src_clk = ~src_clk;

  ckg_ctrl #(.NSYS(NSYS), .NPER(NPER), .DW(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .sys_src_clk_i({NSYS{src_clk}}), .osc_stable_i(osc),
    .pll_a_lock_i(plla), .pll_b_lock_i(pllb), .mck_ready_i(mckr),
    .sys_clk_o(sys_clk), .per_clk_o(per_clk)
  );

  always @(posedge sys_clk[1]) sys_edges++;
  always @(posedge per_clk[5]) per_edges++;

  typedef struct packed {
    logic [3:0]  a;
    logic [31:0] d;
    logic [31:0] es;
    logic [31:0] ep;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{4'h0, 32'h5,        32'h5, 32'h00},  // R2
    '{4'h0, 32'h2,        32'h7, 32'h00},  // R2
    '{4'h1, 32'h4,        32'h3, 32'h00},  // R3
    '{4'h4, 32'h2A,       32'h3, 32'h2A},  // R4
    '{4'h4, 32'h0,        32'h3, 32'h2A},  // R5
    '{4'h1, 32'h0,        32'h3, 32'h2A},  // R5
    '{4'h5, 32'h0A,       32'h3, 32'h20},  // R4
    '{4'h0, 32'hFFFFFFF0, 32'h3, 32'h20},  // R5 bits above width
    '{4'h4, 32'h1F,       32'h3, 32'h3F},  // R4
    '{4'h1, 32'h1,        32'h2, 32'h3F},  // R6
    '{4'h5, 32'h11,       32'h2, 32'h2E}   // R6
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1;
    @(negedge clk);
    wr = 0; wdata = '0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic gate_window(output int s, output int p);
    int s0, p0;
    repeat (3) @(negedge clk);
    s0 = sys_edges; p0 = per_edges;
    repeat (10) @(negedge clk);
    s = sys_edges - s0; p = per_edges - p0;
  endtask

  initial begin
    logic [31:0] v;
    int s, p;
    // R1 reset state
    repeat (3) @(negedge clk);
    rd_reg(4'h2, v); chk("R1 sys state in reset", v, 0);
    rd_reg(4'h6, v); chk("R1 per state in reset", v, 0);
    chk("R1 gated outputs low", {26'b0, per_clk}, 0);
    rst_n = 1;
    gate_window(s, p);
    chk("R1 sys gate idle after reset", s, 0);
    chk("R1 per gate idle after reset", p, 0);

    for (int i = 0; i < NV; i++) begin
      wr_reg(VECS[i].a, VECS[i].d);
      rd_reg(4'h2, v); chk($sformatf("R2/R3 sys state vec %0d", i), v, VECS[i].es);
      rd_reg(4'h6, v); chk($sformatf("R4 per state vec %0d", i), v, VECS[i].ep);
    end

    // R5 writes to read-only and unmapped addresses
    wr_reg(4'h2, 32'hF); wr_reg(4'h6, 32'h3F); wr_reg(4'hA, 32'hFF);
    rd_reg(4'h2, v); chk("R5 sys after ro writes", v, 32'h2);
    rd_reg(4'h6, v); chk("R5 per after ro writes", v, 32'h2E);

    // R8 command and unmapped addresses read 0
    rd_reg(4'h0, v); chk("R8 read sys on", v, 0);
    rd_reg(4'h1, v); chk("R8 read sys off", v, 0);
    rd_reg(4'h5, v); chk("R8 read per off", v, 0);
    rd_reg(4'hF, v); chk("R8 read unmapped", v, 0);

    // R9 gates: sys bit1 on, per bit5 on
    gate_window(s, p);
    chk("R9 sys clk1 runs", s > 0, 1);
    chk("R9 per clk5 runs", p > 0, 1);
    chk("R9 per clk5 edge count", p, 10);
    wr_reg(4'h1, 32'h2); wr_reg(4'h5, 32'h20);
    gate_window(s, p);
    chk("R9 sys clk1 stopped", s, 0);
    chk("R9 per clk5 stopped", p, 0);

    // R7 flags with two-stage latency
    @(negedge clk); osc = 1; pllb = 1;
    rd_reg(4'h8, v); chk("R7 flags unchanged before edge", v, 0);
    @(negedge clk); rd_reg(4'h8, v); chk("R7 flags after one edge", v, 0);
    @(negedge clk); rd_reg(4'h8, v); chk("R7 flags after two edges", v, 32'h5);
    plla = 1; mckr = 1; osc = 0;
    repeat (2) @(negedge clk); rd_reg(4'h8, v); chk("R7 flags mixed", v, 32'hE);

    // R1 reset in the middle of operation
    wr_reg(4'h0, 32'hF); wr_reg(4'h4, 32'h3F);
    @(negedge clk); rst_n = 0; #1;
    rd_reg(4'h2, v); chk("R1 sys cleared by reset", v, 0);
    rd_reg(4'h6, v); chk("R1 per cleared by reset", v, 0);
    rd_reg(4'h8, v); chk("R1 flags cleared by reset", v, 0);
    @(negedge clk); rst_n = 1;

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule